// File: doc/BRIEF.md
# Multi-Channel DMA Request Scheduler

This block is the scheduling core of a DMA controller. It holds a bank of channels. Each channel has its own peripheral request line, a hardware trigger picked from a shared set of trigger inputs, a priority level, a source and destination address, and a remaining-word counter. A channel becomes a candidate once it is enabled and its selected trigger has fired. When the channel is set up to gate on its peripheral request, that request must also be high.

Whenever the bus side is idle, the scheduler picks one candidate and issues a single-word move. It holds the move request, with both addresses and the width, until the bus side returns a done pulse. It then steps the addresses, counts the word, and arbitrates again. Because arbitration runs again after every word, a more urgent channel can break into a long transfer at any word boundary. When a channel moves its last word, it disables itself and raises its interrupt flag. Software clears that flag by writing a one to it.

A single write strobe loads a channel's whole setup in one cycle.

Top module: `dma_sched`

## Requirements
- R1: After reset, `xfer_req_o` is low and every bit of `irq_o` is low.
- R2: A channel is a candidate only when it is enabled and armed. It becomes armed on the first clock edge at which its selected trigger input is high while it is enabled. An enabled channel that has never been triggered is never served.
- R3: The trigger select value t (0 to N_TRIG-1) arms the channel only from `trig_i[t]`. Pulses on any other trigger input leave the channel idle.
- R4: Among candidates, the channel with the numerically lowest priority value is granted. A priority value of 0 is the most urgent.
- R5: Candidates of equal priority are served round-robin in ascending channel order, starting after the last granted channel. After reset, the search starts at channel 0.
- R6: Arbitration runs again after every word. The done cycle is always followed by one cycle with `xfer_req_o` low. A channel that becomes armed during a word, and that has a more urgent priority, gets the next word.
- R7: After each word, the source and destination addresses each advance by a step. The increment code sets a multiplier (0 gives x0, 1 gives x1, 2 gives x2, 3 gives x4). That multiplier scales the transfer size, where a width code of 0 is 1 byte, 1 is 2 bytes, and 2 is 4 bytes.
- R8: A count field of N moves exactly N+1 words. The channel then disables itself and is no longer served.
- R9: The interrupt bit of a channel is set at the edge that completes its last word. Pulsing the matching `irq_clr_i` bit clears it.
- R10: While `xfer_req_o` is high and no done is returned, the channel number, the addresses and the width stay constant.
- R11: A channel with request gating waits while its `periph_req_i` bit is low, and is served once that bit goes high. A channel without gating ignores `periph_req_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Load setup of channel `cfg_ch_i`; also disarms it |
| cfg_ch_i | input | CH_W | Channel being set up |
| cfg_en_i | input | 1 | Channel enable |
| cfg_gate_i | input | 1 | Require peripheral request for eligibility |
| cfg_trig_i | input | TSEL_W | Trigger select |
| cfg_prio_i | input | PRIO_W | Priority, 0 most urgent |
| cfg_width_i | input | 2 | Transfer size code |
| cfg_src_inc_i | input | 2 | Source increment code |
| cfg_dst_inc_i | input | 2 | Destination increment code |
| cfg_count_i | input | CNT_W | Words minus one |
| cfg_src_i | input | ADDR_W | Start source address |
| cfg_dst_i | input | ADDR_W | Start destination address |
| periph_req_i | input | N_CH | Per-channel peripheral requests |
| trig_i | input | N_TRIG | Hardware trigger sources |
| xfer_req_o | output | 1 | Word move request |
| xfer_ch_o | output | CH_W | Channel owning the move |
| xfer_src_o | output | ADDR_W | Source address |
| xfer_dst_o | output | ADDR_W | Destination address |
| xfer_width_o | output | 2 | Transfer size code |
| xfer_done_i | input | 1 | Word completed |
| irq_o | output | N_CH | Per-channel completion flags |
| irq_clr_i | input | N_CH | Write-one-to-clear of completion flags |

## Verification
The bench arms a high-priority channel while a low-priority word is still in flight. A scheduler that only arbitrates at transfer boundaries would hand the next word back to the running channel. Three equal-priority channels are run to expose a round-robin pointer that does not advance or wrap, which shows up as starvation or a repeated channel. Address sequences are checked across all three sizes and several increment codes, and the count is checked for an off-by-one (N words instead of N+1). Triggers arriving on the wrong input, and gated channels with a low request, must leave the bus idle. A block that decodes the select or the gate wrongly would start a move there.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_size_e;

  // byte step for one word: size in bytes times {0,1,2,4}
  function automatic logic [4:0] addr_step(logic [1:0] size, logic [1:0] inc);
    logic [4:0] bytes;
    case (size)
      SZ_BYTE: bytes = 5'd1;
      SZ_HALF: bytes = 5'd2;
      default: bytes = 5'd4;
    endcase
    case (inc)
      2'd0:    addr_step = 5'd0;
      2'd1:    addr_step = bytes;
      2'd2:    addr_step = bytes << 1;
      default: addr_step = bytes << 2;
    endcase
  endfunction
endpackage

// File: rtl/dma_sched_chan.sv
module dma_sched_chan
  import dma_sched_pkg::*;
#(
  parameter int N_TRIG = 9,
  parameter int TSEL_W = 4,
  parameter int PRIO_W = 3,
  parameter int CNT_W  = 10,
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              en_i,
  input  logic              gate_i,
  input  logic [TSEL_W-1:0] tsel_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [1:0]        width_i,
  input  logic [1:0]        sinc_i,
  input  logic [1:0]        dinc_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic              preq_i,
  input  logic              step_i,
  input  logic              irq_clr_i,
  output logic              elig_o,
  output logic [PRIO_W-1:0] prio_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [1:0]        width_o,
  output logic              irq_o
);
  logic              en_q, gate_q, armed_q;
  logic [TSEL_W-1:0] tsel_q;
  logic [1:0]        sinc_q, dinc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              trig_hit, last;

  always_comb begin
    trig_hit = 1'b0;
    for (int t = 0; t < N_TRIG; t++)
      if (tsel_q == TSEL_W'(t) && trig_i[t]) trig_hit = 1'b1;
  end

  assign last   = (cnt_q == '0);
  assign elig_o = en_q & armed_q & (~gate_q | preq_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; gate_q <= 1'b0; armed_q <= 1'b0;
      tsel_q <= '0; prio_o <= '0; width_o <= '0;
      sinc_q <= '0; dinc_q <= '0; cnt_q <= '0;
      src_o <= '0; dst_o <= '0;
    end else if (wr_i) begin
      en_q <= en_i; gate_q <= gate_i; armed_q <= 1'b0;
      tsel_q <= tsel_i; prio_o <= prio_i; width_o <= width_i;
      sinc_q <= sinc_i; dinc_q <= dinc_i; cnt_q <= count_i;
      src_o <= src_i; dst_o <= dst_i;
    end else begin
      if (en_q && trig_hit) armed_q <= 1'b1;
      if (step_i) begin
        src_o <= src_o + ADDR_W'(addr_step(width_o, sinc_q));
        dst_o <= dst_o + ADDR_W'(addr_step(width_o, dinc_q));
        if (last) begin
          en_q    <= 1'b0;
          armed_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              irq_o <= 1'b0;
    else if (step_i && last)  irq_o <= 1'b1;
    else if (irq_clr_i)       irq_o <= 1'b0;
  end
endmodule

// File: rtl/dma_sched_arb.sv
module dma_sched_arb #(
  parameter int N_CH   = 18,
  parameter int CH_W   = 5,
  parameter int PRIO_W = 3
) (
  input  logic [N_CH-1:0]             elig_i,
  input  logic [N_CH-1:0][PRIO_W-1:0] prio_i,
  input  logic [CH_W-1:0]             ptr_i,
  output logic                        any_o,
  output logic [CH_W-1:0]             grant_o
);
  logic [PRIO_W-1:0] best;
  logic              found;

  always_comb begin
    best = '1;
    for (int i = 0; i < N_CH; i++)
      if (elig_i[i] && prio_i[i] < best) best = prio_i[i];
    found   = 1'b0;
    grant_o = '0;
    // rotating search starting one past the last winner
    for (int k = 1; k <= N_CH; k++) begin
      int idx;
      idx = (int'(ptr_i) + k) % N_CH;
      if (!found && elig_i[idx] && prio_i[idx] == best) begin
        found   = 1'b1;
        grant_o = CH_W'(idx);
      end
    end
    any_o = |elig_i;
  end
endmodule

// File: rtl/dma_sched.sv
module dma_sched #(
  parameter int N_CH   = 18,
  parameter int N_TRIG = 9,
  parameter int PRIO_W = 3,
  parameter int CNT_W  = 10,
  parameter int ADDR_W = 32,
  localparam int CH_W   = $clog2(N_CH),
  localparam int TSEL_W = $clog2(N_TRIG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CH_W-1:0]   cfg_ch_i,
  input  logic              cfg_en_i,
  input  logic              cfg_gate_i,
  input  logic [TSEL_W-1:0] cfg_trig_i,
  input  logic [PRIO_W-1:0] cfg_prio_i,
  input  logic [1:0]        cfg_width_i,
  input  logic [1:0]        cfg_src_inc_i,
  input  logic [1:0]        cfg_dst_inc_i,
  input  logic [CNT_W-1:0]  cfg_count_i,
  input  logic [ADDR_W-1:0] cfg_src_i,
  input  logic [ADDR_W-1:0] cfg_dst_i,
  input  logic [N_CH-1:0]   periph_req_i,
  input  logic [N_TRIG-1:0] trig_i,
  output logic              xfer_req_o,
  output logic [CH_W-1:0]   xfer_ch_o,
  output logic [ADDR_W-1:0] xfer_src_o,
  output logic [ADDR_W-1:0] xfer_dst_o,
  output logic [1:0]        xfer_width_o,
  input  logic              xfer_done_i,
  output logic [N_CH-1:0]   irq_o,
  input  logic [N_CH-1:0]   irq_clr_i
);
  logic [N_CH-1:0]             elig;
  logic [N_CH-1:0][PRIO_W-1:0] prio_arr;
  logic [N_CH-1:0][ADDR_W-1:0] src_arr, dst_arr;
  logic [N_CH-1:0][1:0]        width_arr;
  logic                        busy_q, any;
  logic [CH_W-1:0]             act_q, ptr_q, grant;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    dma_sched_chan #(
      .N_TRIG(N_TRIG), .TSEL_W(TSEL_W), .PRIO_W(PRIO_W),
      .CNT_W(CNT_W), .ADDR_W(ADDR_W)
    ) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (cfg_we_i && cfg_ch_i == CH_W'(c)),
      .en_i      (cfg_en_i),
      .gate_i    (cfg_gate_i),
      .tsel_i    (cfg_trig_i),
      .prio_i    (cfg_prio_i),
      .width_i   (cfg_width_i),
      .sinc_i    (cfg_src_inc_i),
      .dinc_i    (cfg_dst_inc_i),
      .count_i   (cfg_count_i),
      .src_i     (cfg_src_i),
      .dst_i     (cfg_dst_i),
      .trig_i    (trig_i),
      .preq_i    (periph_req_i[c]),
      .step_i    (busy_q && xfer_done_i && act_q == CH_W'(c)),
      .irq_clr_i (irq_clr_i[c]),
      .elig_o    (elig[c]),
      .prio_o    (prio_arr[c]),
      .src_o     (src_arr[c]),
      .dst_o     (dst_arr[c]),
      .width_o   (width_arr[c]),
      .irq_o     (irq_o[c])
    );
  end

  dma_sched_arb #(.N_CH(N_CH), .CH_W(CH_W), .PRIO_W(PRIO_W)) u_arb (
    .elig_i  (elig),
    .prio_i  (prio_arr),
    .ptr_i   (ptr_q),
    .any_o   (any),
    .grant_o (grant)
  );

  // one idle cycle between words is where arbitration re-runs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      act_q  <= '0;
      ptr_q  <= CH_W'(N_CH - 1);
    end else if (busy_q) begin
      if (xfer_done_i) busy_q <= 1'b0;
    end else if (any) begin
      busy_q <= 1'b1;
      act_q  <= grant;
      ptr_q  <= grant;
    end
  end

  assign xfer_req_o   = busy_q;
  assign xfer_ch_o    = act_q;
  assign xfer_src_o   = src_arr[act_q];
  assign xfer_dst_o   = dst_arr[act_q];
  assign xfer_width_o = width_arr[act_q];
endmodule

// File: rtl/dma_sched_chk.sv
module dma_sched_chk #(
  parameter int N_CH   = 18,
  parameter int CH_W   = 5,
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              xfer_req_o,
  input logic [CH_W-1:0]   xfer_ch_o,
  input logic [ADDR_W-1:0] xfer_src_o,
  input logic [ADDR_W-1:0] xfer_dst_o,
  input logic [1:0]        xfer_width_o,
  input logic              xfer_done_i,
  input logic [N_CH-1:0]   irq_o,
  input logic [N_CH-1:0]   elig_i
);
  logic [N_CH-1:0] elig_d;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) elig_d <= '0;
    else         elig_d <= elig_i;
  end

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && !xfer_done_i |=> xfer_req_o && $stable(xfer_ch_o) &&
      $stable(xfer_src_o) && $stable(xfer_dst_o) && $stable(xfer_width_o));

  p_rearb_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o && xfer_done_i |=> !xfer_req_o);

  p_grant_elig_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(xfer_req_o) |-> elig_d[xfer_ch_o]);

  p_ch_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_req_o |-> int'(xfer_ch_o) < N_CH);

  p_irq_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(irq_o & ~$past(irq_o)) |->
      $past(xfer_req_o && xfer_done_i) && $countones(irq_o & ~$past(irq_o)) == 1);
endmodule

bind dma_sched dma_sched_chk #(.N_CH(N_CH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .xfer_req_o   (xfer_req_o),
  .xfer_ch_o    (xfer_ch_o),
  .xfer_src_o   (xfer_src_o),
  .xfer_dst_o   (xfer_dst_o),
  .xfer_width_o (xfer_width_o),
  .xfer_done_i  (xfer_done_i),
  .irq_o        (irq_o),
  .elig_i       (elig)
);

// File: tb/dma_sched_test.sv
`timescale 1ns/1ps
module dma_sched_test;
  localparam int N_CH = 18, N_TRIG = 9, PRIO_W = 3, CNT_W = 10, ADDR_W = 32;
  localparam int CH_W = 5, TSEL_W = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cfg_we_i = 1'b0, cfg_en_i = 1'b0, cfg_gate_i = 1'b0;
  logic [CH_W-1:0] cfg_ch_i = '0;
  logic [TSEL_W-1:0] cfg_trig_i = '0;
  logic [PRIO_W-1:0] cfg_prio_i = '0;
  logic [1:0] cfg_width_i = '0, cfg_src_inc_i = '0, cfg_dst_inc_i = '0;
  logic [CNT_W-1:0] cfg_count_i = '0;
  logic [ADDR_W-1:0] cfg_src_i = '0, cfg_dst_i = '0;
  logic [N_CH-1:0] periph_req_i = '0, irq_clr_i = '0;
  logic [N_TRIG-1:0] trig_i = '0;
  logic xfer_done_i = 1'b0;
  logic xfer_req_o;
  logic [CH_W-1:0] xfer_ch_o;
  logic [ADDR_W-1:0] xfer_src_o, xfer_dst_o;
  logic [1:0] xfer_width_o;
  logic [N_CH-1:0] irq_o;

  int checks = 0, fails = 0;
  int log_ch[16];
  logic [ADDR_W-1:0] log_src[16], log_dst[16];
  int nlog;

  always #4 clk_i = ~clk_i;

  dma_sched uut (.*);

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    periph_req_i = '0; trig_i = '0; xfer_done_i = 1'b0; irq_clr_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic cfg(input int ch, input bit gate, input int tsel, input int prio,
                     input int width, input int sinc, input int dinc, input int cnt,
                     input logic [ADDR_W-1:0] src, input logic [ADDR_W-1:0] dst);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_ch_i = CH_W'(ch); cfg_en_i = 1'b1; cfg_gate_i = gate;
    cfg_trig_i = TSEL_W'(tsel); cfg_prio_i = PRIO_W'(prio); cfg_width_i = 2'(width);
    cfg_src_inc_i = 2'(sinc); cfg_dst_inc_i = 2'(dinc); cfg_count_i = CNT_W'(cnt);
    cfg_src_i = src; cfg_dst_i = dst;
    @(negedge clk_i); cfg_we_i = 1'b0;
  endtask

  task automatic pulse_trig(input int t);
    trig_i[t] = 1'b1;
    @(negedge clk_i); trig_i[t] = 1'b0;
  endtask

  task automatic wait_req(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 50 && !ok; i++) begin
      if (xfer_req_o) ok = 1'b1;
      else @(negedge clk_i);
    end
  endtask

  // called at a negedge with xfer_req_o high
  task automatic give_done();
    log_ch[nlog] = int'(xfer_ch_o); log_src[nlog] = xfer_src_o; log_dst[nlog] = xfer_dst_o;
    nlog++;
    xfer_done_i = 1'b1;
    @(negedge clk_i); xfer_done_i = 1'b0;
  endtask

  task automatic serve(input int n, input string req);
    for (int w = 0; w < n; w++) begin
      bit ok;
      wait_req(ok);
      check(ok, req, 0, 1);
      if (!ok) return;
      give_done();
    end
  endtask

  task automatic expect_idle(input int cyc, input string req);
    bit seen = 1'b0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk_i);
      if (xfer_req_o) seen = 1'b1;
    end
    check(!seen, req, seen, 0);
  endtask

  task automatic expect_chs(input int exp[], input string req);
    check(nlog == exp.size(), req, nlog, exp.size());
    for (int i = 0; i < exp.size() && i < nlog; i++)
      check(log_ch[i] == exp[i], req, log_ch[i], exp[i]);
  endtask

  task automatic t_reset();
    do_reset();
    check(xfer_req_o == 1'b0, "R1 req", xfer_req_o, 0);
    check(irq_o == '0, "R1 irq", irq_o, 0);
  endtask

  task automatic t_trigger();
    do_reset(); nlog = 0;
    cfg(3, 0, 2, 1, 2, 1, 1, 0, 32'h100, 32'h200);
    expect_idle(10, "R2 untriggered channel idle");
    pulse_trig(5);
    expect_idle(10, "R3 wrong trigger ignored");
    pulse_trig(2);
    serve(1, "R3 selected trigger arms");
    expect_chs('{3}, "R3 channel");
    check(irq_o[3] == 1'b1, "R9 irq set", irq_o[3], 1);
    irq_clr_i[3] = 1'b1;
    @(negedge clk_i); irq_clr_i = '0;
    check(irq_o[3] == 1'b0, "R9 irq cleared", irq_o[3], 0);
  endtask

  task automatic t_addr();
    do_reset(); nlog = 0;
    cfg(0, 0, 0, 2, 1, 3, 0, 3, 32'h1000, 32'h4000_0000);
    pulse_trig(0);
    serve(4, "R8 four words");
    expect_idle(10, "R8 stops after count");
    for (int i = 0; i < 4; i++) begin
      check(log_src[i] == 32'h1000 + 32'(8 * i), "R7 half x4 src", log_src[i], 32'h1000 + 8 * i);
      check(log_dst[i] == 32'h4000_0000, "R7 fixed dst", log_dst[i], 32'h4000_0000);
    end
    check(irq_o[0] == 1'b1, "R8 irq at end", irq_o[0], 1);
    nlog = 0;
    cfg(1, 0, 4, 2, 2, 1, 2, 1, 32'h2000, 32'h3000);
    pulse_trig(4);
    serve(2, "R7 word size");
    check(log_src[1] == 32'h2004, "R7 word x1 src", log_src[1], 32'h2004);
    check(log_dst[1] == 32'h3008, "R7 word x2 dst", log_dst[1], 32'h3008);
    nlog = 0;
    cfg(15, 0, 8, 2, 0, 2, 1, 1, 32'h10, 32'h20);
    pulse_trig(8);
    serve(2, "R7 byte size");
    check(log_src[1] == 32'h12, "R7 byte x2 src", log_src[1], 32'h12);
    check(log_dst[1] == 32'h21, "R7 byte x1 dst", log_dst[1], 32'h21);
  endtask

  task automatic t_priority();
    do_reset(); nlog = 0;
    cfg(5, 0, 1, 4, 2, 1, 1, 1, 32'h0, 32'h0);
    cfg(9, 0, 1, 1, 2, 1, 1, 1, 32'h0, 32'h0);
    pulse_trig(1);
    serve(4, "R4 serve");
    expect_chs('{9, 9, 5, 5}, "R4 lower value first");
  endtask

  task automatic t_rr();
    do_reset(); nlog = 0;
    cfg(12, 0, 6, 3, 2, 1, 1, 1, 32'h0, 32'h0);
    cfg(2, 0, 6, 3, 2, 1, 1, 1, 32'h0, 32'h0);
    cfg(7, 0, 6, 3, 2, 1, 1, 1, 32'h0, 32'h0);
    pulse_trig(6);
    serve(6, "R5 serve");
    expect_chs('{2, 7, 12, 2, 7, 12}, "R5 round robin");
  endtask

  task automatic t_preempt();
    bit ok;
    do_reset(); nlog = 0;
    cfg(4, 0, 1, 5, 2, 1, 1, 3, 32'h0, 32'h0);
    cfg(10, 0, 7, 0, 2, 1, 1, 0, 32'h0, 32'h0);
    pulse_trig(1);
    wait_req(ok);
    check(ok, "R6 first word", ok, 1);
    // hold the word open and confirm outputs are steady
    @(negedge clk_i); @(negedge clk_i);
    check(xfer_req_o && xfer_ch_o == 5'd4, "R10 held", xfer_ch_o, 4);
    pulse_trig(7);
    check(xfer_req_o && xfer_ch_o == 5'd4, "R10 held while arming", xfer_ch_o, 4);
    give_done();
    check(!xfer_req_o, "R6 gap after done", xfer_req_o, 0);
    serve(4, "R6 serve");
    expect_chs('{4, 10, 4, 4, 4}, "R6 preempt at word boundary");
  endtask

  task automatic t_gate();
    do_reset(); nlog = 0;
    cfg(6, 1, 3, 2, 2, 1, 1, 0, 32'h0, 32'h0);
    cfg(8, 0, 3, 2, 2, 1, 1, 0, 32'h0, 32'h0);
    pulse_trig(3);
    serve(1, "R11 ungated");
    expect_idle(10, "R11 gated waits");
    check(irq_o[6] == 1'b0, "R11 gated not done", irq_o[6], 0);
    periph_req_i[6] = 1'b1;
    serve(1, "R11 gated released");
    expect_chs('{8, 6}, "R11 order");
    periph_req_i = '0;
  endtask

  bit finished = 1'b0;

  initial begin
    t_reset();
    t_trigger();
    t_addr();
    t_priority();
    t_rr();
    t_preempt();
    t_gate();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8ns * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule